// File: doc/BRIEF.md
# Debug-Aware Power Mode Sequencer

This block decides which power mode a chip actually enters when the system asks for a change, taking into account whether an external debugger is attached. The system presents a mode request as a valid flag plus a 3-bit mode code. The block accepts only legal moves and holds its mode when a request is not legal. Every low-power mode is left through a wakeup input, which returns the chip to the run mode it left.

An attached debugger changes the outcome in three ways. A request for deep stop becomes a plain stop, and a status flag marks that substitution. The core clock stays enabled in the stop modes so that core registers and trace remain reachable. The debug logic is treated according to how deep the mode is. In retention stop the debug state is kept but debug access is blocked, and the two-wire debug controller gets a reset pulse on the way out. In power-off stop the debug logic is held in reset, the debugger-attached indication is cleared, and the system can optionally be held in reset after wakeup until the debugger releases it.

Mode codes are: RUN=0, LPRUN=1 (low-power run), WAIT=2, LPWAIT=3 (low-power wait), STOP=4, DEEPSTOP=5, RETSTOP=6 (retention stop), OFFSTOP=7 (power-off stop). RUN and LPRUN are the run modes. Every other code is a low-power mode.

Top module: `lpm_ctrl`

## Requirements
- R1: After synchronous reset, mode_o is RUN (0), core_clk_en_o and dbg_access_en_o are 1, and dbg_rst_o, twowire_rst_o, sys_hold_o and pseudo_deep_o are 0.
- R2: The debugger counts as attached when dbg_pwr_req_i or sys_pwr_req_i is 1. This indication is sampled only on clock edges where the current mode is RUN, LPRUN, WAIT or LPWAIT. Changes made while in STOP, DEEPSTOP or RETSTOP have no effect until a later sampling edge.
- R3: A request (req_valid_i=1) is accepted only for these moves: from RUN to LPRUN, WAIT, STOP, DEEPSTOP, RETSTOP or OFFSTOP; from LPRUN to RUN, LPWAIT, DEEPSTOP, RETSTOP or OFFSTOP. Any other request leaves mode_o unchanged. An accepted request shows on mode_o one cycle later.
- R4: A DEEPSTOP request from RUN while the debugger is attached enters STOP (4) and sets pseudo_deep_o to 1. When the debugger is not attached, DEEPSTOP is entered and pseudo_deep_o stays 0.
- R5: A DEEPSTOP request from LPRUN while the debugger is attached also enters STOP and sets pseudo_deep_o.
- R6: pseudo_deep_o returns to 0 when the demoted stop is left.
- R7: core_clk_en_o is 1 in RUN and LPRUN. In STOP and DEEPSTOP it equals the sampled debugger-attached indication. In WAIT, LPWAIT, RETSTOP and OFFSTOP it is 0.
- R8: In any low-power mode, wakeup_i=1 returns the mode one cycle later to the run mode held before entry. Requests are ignored while in a low-power mode. wakeup_i has no effect in a run mode.
- R9: In RETSTOP, dbg_access_en_o is 0 and the debugger-attached indication is retained. On exit, twowire_rst_o is 1 for one cycle, in the same cycle that mode_o shows the run mode.
- R10: In OFFSTOP, dbg_access_en_o is 0 and dbg_rst_o is 1. dbg_rst_o stays 1 for one cycle after the exit. The exit also clears the debugger-attached indication.
- R11: If hold_en_i is 1 at an OFFSTOP exit, sys_hold_o goes to 1 with the mode change. It stays 1 until a cycle with hold_release_i=1, and reads 0 one cycle after that cycle. If hold_en_i is 0 at the exit, sys_hold_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Mode request valid |
| req_mode_i | input | 3 | Requested mode code |
| wakeup_i | input | 1 | Wakeup event from a low-power mode |
| dbg_pwr_req_i | input | 1 | Debug power-up request from the debug port |
| sys_pwr_req_i | input | 1 | System power-up request from the debug port |
| hold_en_i | input | 1 | Debugger control: hold the system in reset after power-off stop exit |
| hold_release_i | input | 1 | Debugger releases the system reset hold |
| mode_o | output | 3 | Current power mode code |
| core_clk_en_o | output | 1 | Core clock enable |
| dbg_access_en_o | output | 1 | Debug activity permitted |
| dbg_rst_o | output | 1 | Debug logic reset |
| twowire_rst_o | output | 1 | Reset pulse to the two-wire debug controller |
| sys_hold_o | output | 1 | System held in reset |
| pseudo_deep_o | output | 1 | Deep stop was demoted to stop |

## Verification
Mode changes, the demotion flag, the exit pulses and the reset hold are all registered at the edge that sees the request or wakeup, so each shows one cycle later. The clock enable and the debug access enable follow the new mode in that same cycle. The debugger-attached indication needs one sampling edge in a run or wait mode before a request can act on it, and the stimulus places idle cycles wherever that delay matters.

The driver queues the expected output vector for each cycle it drives. The monitor compares that vector on the falling edge that follows the next rising edge. Every check therefore lands on the first cycle in which a result is due.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        PM_RUN      = 3'd0,
        PM_LPRUN    = 3'd1,
        PM_WAIT     = 3'd2,
        PM_LPWAIT   = 3'd3,
        PM_STOP     = 3'd4,
        PM_DEEPSTOP = 3'd5,
        PM_RETSTOP  = 3'd6,
        PM_OFFSTOP  = 3'd7
    } pmode_e;

    typedef struct packed {
        logic   vld;
        pmode_e tgt;
    } mode_req_t;

    typedef struct packed {
        pmode_e mode;
        pmode_e ret;
        logic   demoted;
    } fsm_state_t;

    typedef struct packed {
        logic ret_exit;
        logic off_exit;
    } exit_evt_t;

    function automatic logic is_run_mode(pmode_e m);
        return (m == PM_RUN) || (m == PM_LPRUN);
    endfunction

    // modes in which the debugger indication is sampled
    function automatic logic is_sample_mode(pmode_e m);
        return (m == PM_RUN) || (m == PM_LPRUN) || (m == PM_WAIT) || (m == PM_LPWAIT);
    endfunction

    function automatic logic is_low_power(pmode_e m);
        return !is_run_mode(m);
    endfunction

    function automatic logic legal_move(pmode_e from, pmode_e to);
        logic ok;
        case (from)
            PM_RUN:   ok = (to == PM_LPRUN) || (to == PM_WAIT) || (to == PM_STOP) ||
                           (to == PM_DEEPSTOP) || (to == PM_RETSTOP) || (to == PM_OFFSTOP);
            PM_LPRUN: ok = (to == PM_RUN) || (to == PM_LPWAIT) || (to == PM_DEEPSTOP) ||
                           (to == PM_RETSTOP) || (to == PM_OFFSTOP);
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/lpm_pulse_gen.sv
module lpm_pulse_gen #(
    parameter int CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic pulse_o
);
    generate
        if (CYCLES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= trig_i;
            end
            assign pulse_o = q;
        end else begin : g_count
            localparam int CW = $clog2(CYCLES + 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)             cnt <= '0;
                else if (trig_i)     cnt <= CW'(CYCLES);
                else if (cnt != '0)  cnt <= cnt - 1'b1;
            end
            assign pulse_o = (cnt != '0);
        end
    endgenerate

    AST_PULSE_FROM_TRIG: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> $past(trig_i)); // R9
endmodule

// File: rtl/lpm_dbg_track.sv
module lpm_dbg_track
    import lpm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  pmode_e mode_i,
    input  logic   dbg_pwr_req_i,
    input  logic   sys_pwr_req_i,
    input  logic   clear_i,
    output logic   active_o
);
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst)                         active_q <= 1'b0;
        else if (clear_i)                active_q <= 1'b0;
        else if (is_sample_mode(mode_i)) active_q <= dbg_pwr_req_i | sys_pwr_req_i;
    end

    assign active_o = active_q;

    AST_FROZEN_IN_STOP: assert property (@(posedge clk) disable iff (rst)
        (mode_i == PM_STOP || mode_i == PM_DEEPSTOP || mode_i == PM_RETSTOP) |=> $stable(active_o)); // R2
    AST_CLEAR_ON_OFF: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !active_o); // R10
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mode_req_t req_i,
    input  logic      wakeup_i,
    input  logic      dbg_active_i,
    output pmode_e    mode_o,
    output logic      demoted_o,
    output exit_evt_t exit_o
);
    fsm_state_t st_q, st_d;
    logic take_wake;
    logic take_req;

    always_comb begin
        take_wake = is_low_power(st_q.mode) && wakeup_i;
        take_req  = !take_wake && req_i.vld && legal_move(st_q.mode, req_i.tgt);
        st_d = st_q;
        if (take_wake) begin
            st_d.mode    = st_q.ret;
            st_d.demoted = 1'b0;
        end else if (take_req) begin
            st_d.ret = st_q.mode;
            if (req_i.tgt == PM_DEEPSTOP && dbg_active_i) begin
                st_d.mode    = PM_STOP;
                st_d.demoted = 1'b1;
            end else begin
                st_d.mode    = req_i.tgt;
                st_d.demoted = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode    <= PM_RUN;
            st_q.ret     <= PM_RUN;
            st_q.demoted <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o          = st_q.mode;
    assign demoted_o       = st_q.demoted;
    assign exit_o.ret_exit = take_wake && (st_q.mode == PM_RETSTOP);
    assign exit_o.off_exit = take_wake && (st_q.mode == PM_OFFSTOP);

    AST_LP_HOLDS_MODE: assert property (@(posedge clk) disable iff (rst)
        (is_low_power(mode_o) && !wakeup_i) |=> $stable(mode_o)); // R8
    AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (rst)
        (is_low_power(mode_o) && wakeup_i) |=> is_run_mode(mode_o)); // R8
    AST_DEMOTE_IS_STOP: assert property (@(posedge clk) disable iff (rst)
        demoted_o |-> (mode_o == PM_STOP)); // R4
    AST_NO_DEEP_WITH_DBG: assert property (@(posedge clk) disable iff (rst)
        (req_i.vld && req_i.tgt == PM_DEEPSTOP && dbg_active_i && is_run_mode(mode_o))
        |=> (mode_o == PM_STOP)); // R5
endmodule

// File: rtl/lpm_dbg_ctrl.sv
module lpm_dbg_ctrl
    import lpm_pkg::*;
#(
    parameter int TW_RST_CYCLES  = 1,
    parameter int DBG_RST_EXT    = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  pmode_e    mode_i,
    input  logic      dbg_active_i,
    input  exit_evt_t exit_i,
    input  logic      hold_en_i,
    input  logic      hold_release_i,
    output logic      core_clk_en_o,
    output logic      dbg_access_en_o,
    output logic      dbg_rst_o,
    output logic      twowire_rst_o,
    output logic      sys_hold_o
);
    logic dbg_ext;
    logic hold_q;

    lpm_pulse_gen #(.CYCLES(TW_RST_CYCLES)) i_tw_pulse (
        .clk(clk), .rst(rst), .trig_i(exit_i.ret_exit), .pulse_o(twowire_rst_o)
    );

    lpm_pulse_gen #(.CYCLES(DBG_RST_EXT)) i_dbg_pulse (
        .clk(clk), .rst(rst), .trig_i(exit_i.off_exit), .pulse_o(dbg_ext)
    );

    always_comb begin
        case (mode_i)
            PM_RUN, PM_LPRUN:     core_clk_en_o = 1'b1;
            PM_STOP, PM_DEEPSTOP: core_clk_en_o = dbg_active_i;
            default:              core_clk_en_o = 1'b0;
        endcase
    end

    assign dbg_access_en_o = !(mode_i == PM_RETSTOP || mode_i == PM_OFFSTOP);
    assign dbg_rst_o       = (mode_i == PM_OFFSTOP) || dbg_ext;

    always_ff @(posedge clk) begin
        if (rst)                                hold_q <= 1'b0;
        else if (exit_i.off_exit && hold_en_i)  hold_q <= 1'b1;
        else if (hold_release_i)                hold_q <= 1'b0;
    end

    assign sys_hold_o = hold_q;

    AST_HOLD_AFTER_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_hold_o) |-> ($past(mode_i) == PM_OFFSTOP)); // R11
    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (sys_hold_o && hold_release_i && !exit_i.off_exit) |=> !sys_hold_o); // R11
    AST_TW_AFTER_RET: assert property (@(posedge clk) disable iff (rst)
        $rose(twowire_rst_o) |-> ($past(mode_i) == PM_RETSTOP)); // R9
    AST_DBG_RST_LEAVES_OFF: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == PM_OFFSTOP && mode_i != PM_OFFSTOP) |-> dbg_rst_o); // R10
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int TW_RST_CYCLES = 1,
    parameter int DBG_RST_EXT   = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid_i,
    input  logic [2:0] req_mode_i,
    input  logic       wakeup_i,
    input  logic       dbg_pwr_req_i,
    input  logic       sys_pwr_req_i,
    input  logic       hold_en_i,
    input  logic       hold_release_i,
    output logic [2:0] mode_o,
    output logic       core_clk_en_o,
    output logic       dbg_access_en_o,
    output logic       dbg_rst_o,
    output logic       twowire_rst_o,
    output logic       sys_hold_o,
    output logic       pseudo_deep_o
);
    mode_req_t req;
    pmode_e    mode;
    logic      dbg_active;
    exit_evt_t exits;

    assign req.vld = req_valid_i;
    assign req.tgt = pmode_e'(req_mode_i);

    lpm_dbg_track i_track (
        .clk(clk), .rst(rst), .mode_i(mode),
        .dbg_pwr_req_i(dbg_pwr_req_i), .sys_pwr_req_i(sys_pwr_req_i),
        .clear_i(exits.off_exit), .active_o(dbg_active)
    );

    lpm_mode_fsm i_fsm (
        .clk(clk), .rst(rst), .req_i(req), .wakeup_i(wakeup_i),
        .dbg_active_i(dbg_active), .mode_o(mode),
        .demoted_o(pseudo_deep_o), .exit_o(exits)
    );

    lpm_dbg_ctrl #(.TW_RST_CYCLES(TW_RST_CYCLES), .DBG_RST_EXT(DBG_RST_EXT)) i_dctl (
        .clk(clk), .rst(rst), .mode_i(mode), .dbg_active_i(dbg_active),
        .exit_i(exits), .hold_en_i(hold_en_i), .hold_release_i(hold_release_i),
        .core_clk_en_o(core_clk_en_o), .dbg_access_en_o(dbg_access_en_o),
        .dbg_rst_o(dbg_rst_o), .twowire_rst_o(twowire_rst_o), .sys_hold_o(sys_hold_o)
    );

    assign mode_o = mode;

    AST_RESET_RUN: assert property (@(posedge clk)
        rst |=> (mode_o == 3'd0 && !sys_hold_o && !pseudo_deep_o)); // R1
    AST_CLK_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd0 || mode_o == 3'd1) |-> core_clk_en_o); // R7
endmodule

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
    localparam logic [2:0] RUN = 3'd0, LPRUN = 3'd1, WAIT = 3'd2, LPWAIT = 3'd3,
                           STOP = 3'd4, DEEP = 3'd5, RET = 3'd6, OFF = 3'd7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid_i = 1'b0;
    logic [2:0] req_mode_i = 3'd0;
    logic wakeup_i = 1'b0, dbg_pwr_req_i = 1'b0, sys_pwr_req_i = 1'b0;
    logic hold_en_i = 1'b0, hold_release_i = 1'b0;
    logic [2:0] mode_o;
    logic core_clk_en_o, dbg_access_en_o, dbg_rst_o, twowire_rst_o, sys_hold_o, pseudo_deep_o;

    lpm_ctrl i_lpm_ctrl (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_mode_i(req_mode_i),
        .wakeup_i(wakeup_i), .dbg_pwr_req_i(dbg_pwr_req_i), .sys_pwr_req_i(sys_pwr_req_i),
        .hold_en_i(hold_en_i), .hold_release_i(hold_release_i),
        .mode_o(mode_o), .core_clk_en_o(core_clk_en_o), .dbg_access_en_o(dbg_access_en_o),
        .dbg_rst_o(dbg_rst_o), .twowire_rst_o(twowire_rst_o), .sys_hold_o(sys_hold_o),
        .pseudo_deep_o(pseudo_deep_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [8:0] vec;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // vector layout: mode[8:6] clk_en dbg_en dbg_rst tw_rst hold pseudo
    task automatic step(string tag, logic [2:0] m, logic ce, logic de, logic dr,
                        logic tr, logic hd, logic ps);
        exp_t e;
        e.vec = {m, ce, de, dr, tr, hd, ps};
        e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        req_valid_i    = 1'b0;
        wakeup_i       = 1'b0;
        hold_release_i = 1'b0;
    endtask

    task automatic req(logic [2:0] m);
        req_valid_i = 1'b1;
        req_mode_i  = m;
    endtask

    initial begin : monitor
        forever begin
            int n;
            @(posedge clk);
            n = sbq.size();
            @(negedge clk);
            #1;
            if (n > 0) begin
                exp_t e;
                logic [8:0] act;
                e = sbq.pop_front();
                act = {mode_o, core_clk_en_o, dbg_access_en_o, dbg_rst_o,
                       twowire_rst_o, sys_hold_o, pseudo_deep_o};
                checks++;
                if (act !== e.vec) begin
                    failures++;
                    $display("FAIL %s actual=%b expected=%b", e.tag, act, e.vec);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step("R1 reset state", RUN, 1,1,0,0,0,0);
        req(LPWAIT); step("R3 illegal run->lpwait", RUN, 1,1,0,0,0,0);
        req(RUN);    step("R3 same-mode request", RUN, 1,1,0,0,0,0);
        req(WAIT);   step("R3 R7 run->wait clock off", WAIT, 0,1,0,0,0,0);
        req(STOP);   step("R8 request ignored in wait", WAIT, 0,1,0,0,0,0);
        wakeup_i = 1; step("R8 wait->run", RUN, 1,1,0,0,0,0);
        wakeup_i = 1; step("R8 wakeup ignored in run", RUN, 1,1,0,0,0,0);
        req(DEEP);   step("R4 deepstop without debugger", DEEP, 0,1,0,0,0,0);
        dbg_pwr_req_i = 1;
        step("R2 not sampled in deepstop", DEEP, 0,1,0,0,0,0);
        wakeup_i = 1; step("R8 deepstop->run", RUN, 1,1,0,0,0,0);
        step("R2 sampled in run", RUN, 1,1,0,0,0,0);
        req(DEEP);   step("R4 R7 demoted to stop, clock kept", STOP, 1,1,0,0,0,1);
        wakeup_i = 1; step("R6 flag clears on exit", RUN, 1,1,0,0,0,0);
        dbg_pwr_req_i = 0; sys_pwr_req_i = 1;
        req(LPRUN);  step("R3 run->lprun", LPRUN, 1,1,0,0,0,0);
        req(DEEP);   step("R5 demote from lprun", STOP, 1,1,0,0,0,1);
        wakeup_i = 1; step("R8 R6 return to lprun", LPRUN, 1,1,0,0,0,0);
        req(WAIT);   step("R3 illegal lprun->wait", LPRUN, 1,1,0,0,0,0);
        req(LPWAIT); step("R3 R7 lprun->lpwait", LPWAIT, 0,1,0,0,0,0);
        wakeup_i = 1; step("R8 lpwait->lprun", LPRUN, 1,1,0,0,0,0);
        sys_pwr_req_i = 0;
        req(RUN);    step("R3 lprun->run", RUN, 1,1,0,0,0,0);
        req(STOP);   step("R7 stop without debugger", STOP, 0,1,0,0,0,0);
        wakeup_i = 1; step("R8 stop->run", RUN, 1,1,0,0,0,0);
        dbg_pwr_req_i = 1;
        step("R2 dbg power request sampled", RUN, 1,1,0,0,0,0);
        req(STOP);   step("R7 stop with debugger", STOP, 1,1,0,0,0,0);
        wakeup_i = 1; step("R8 stop->run", RUN, 1,1,0,0,0,0);
        req(RET);    step("R9 retstop blocks debug", RET, 0,0,0,0,0,0);
        dbg_pwr_req_i = 0;
        step("R9 R2 retstop holds", RET, 0,0,0,0,0,0);
        wakeup_i = 1; step("R9 two-wire reset pulse", RUN, 1,1,0,1,0,0);
        req(DEEP);   step("R9 indication retained", STOP, 0,1,0,0,0,1);
        wakeup_i = 1; step("R6 exit", RUN, 1,1,0,0,0,0);
        dbg_pwr_req_i = 1; hold_en_i = 1;
        step("R2 sample", RUN, 1,1,0,0,0,0);
        req(OFF);    step("R10 offstop debug reset", OFF, 0,0,1,0,0,0);
        step("R10 offstop stays", OFF, 0,0,1,0,0,0);
        wakeup_i = 1; step("R10 R11 exit with hold", RUN, 1,1,1,0,1,0);
        req(DEEP);   step("R10 indication cleared", DEEP, 1,1,0,0,1,0);
        wakeup_i = 1; step("R11 hold persists", RUN, 1,1,0,0,1,0);
        hold_release_i = 1; step("R11 hold released", RUN, 1,1,0,0,0,0);
        hold_en_i = 0;
        req(OFF);    step("R10 offstop again", OFF, 0,0,1,0,0,0);
        wakeup_i = 1; step("R11 no hold when disabled", RUN, 1,1,1,0,0,0);
        req(LPRUN);  step("R3 run->lprun", LPRUN, 1,1,0,0,0,0);
        req(STOP);   step("R3 illegal lprun->stop", LPRUN, 1,1,0,0,0,0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule